// File: doc/BRIEF.md
# SDRAM Host Command Sequencer

This block is the user-facing front end of an SDRAM controller. After reset it waits out a power-up delay. It then drives an ordered set of initialisation commands to a downstream command engine. Once the memory and the engine are configured, it accepts single-cycle read and write requests with a flat address. Each request becomes a 3-bit command code plus a value on a shared parameter/address bus. The sequencer holds every command until the engine acknowledges it, and then returns the code to NOP.

The user never asks for refresh. A free-running interval timer starts when initialisation ends. Each time it expires, the sequencer inserts a precharge-all command followed by a refresh command. Two flags tell the user what to do. The busy flag (0 = idle, 1 = busy) says when a request will be taken. The data-enable flag marks the cycles in which write data may be driven or read data collected.

States: `ST_WAIT_PWR` moves to `ST_INIT_PRE` when the power-up delay ends. Each acknowledged command then moves one step along `ST_INIT_PRE` → `ST_INIT_REF` (repeated) → `ST_INIT_MODE` → `ST_INIT_CTRL` → `ST_INIT_RCNT` → `ST_IDLE`. From `ST_IDLE`, a pending refresh moves to `ST_RUN_PRE`, and its acknowledge moves to `ST_RUN_REF`. The acknowledge of `ST_RUN_REF` returns to `ST_IDLE`. Otherwise, a read or write request moves from `ST_IDLE` to `ST_XFER_CMD`. Its acknowledge moves to `ST_XFER_DATA`, which returns to `ST_IDLE` after the data window.

Top module: `sdram_cmd_seq`

## Requirements
- R1: In reset and afterwards until the power-up delay ends, `eng_cmd` is 000, `usr_busy` is 1 and `usr_data_en` is 0. The first command appears no earlier than PWRUP_CYCLES and no later than PWRUP_CYCLES+2 clock edges after reset is released.
- R2: Initialisation issues the following commands in this order:
  - precharge (100), with only bus bit 10 set;
  - INIT_REFRESHES refreshes (011), each with bus 0;
  - load-mode (101), with MODE_WORD on the bus;
  - load-controller-word (110), with CTRL_WORD on the bus;
  - load-refresh-count (111), with REF_PERIOD on the bus.
- R3: In the cycle after `eng_ack` is sampled high while a command is shown, `eng_cmd` is 000 (NOP).
- R4: A non-NOP command and its bus value stay unchanged until the engine acknowledges that command.
- R5: A read request accepted in idle issues command 001, with the request address on the bus.
- R6: A write request accepted in idle issues command 010, with the request address on the bus.
- R7: `usr_busy` is 0 only in idle. Requests made while busy or before initialisation ends are ignored and issue no command.
- R8: After the engine acknowledges a read or write command, `usr_data_en` is 1 for exactly DATA_BEATS cycles, starting in the cycle after the acknowledge. It is 0 at all other times.
- R9: After initialisation, a precharge (100, bus bit 10 set) followed by a refresh (011, bus 0) is issued automatically. When the block is idle at each expiry, successive precharges are REF_PERIOD cycles apart.
- R10: When a refresh falls due in the same cycle as a user request, the refresh is issued and the request is dropped.
- R11: When read and write are both asserted in idle, the read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_rd | input | 1 | Read request, sampled when idle |
| usr_wr | input | 1 | Write request, sampled when idle |
| usr_addr | input | ADDR_W | Flat request address |
| usr_busy | output | 1 | 0 = idle and ready, 1 = busy |
| usr_data_en | output | 1 | Data phase window for the user |
| eng_cmd | output | 3 | Command code to the engine |
| eng_bus | output | ADDR_W | Parameter or address for the command |
| eng_ack | input | 1 | Engine acknowledge of the shown command |

## Verification
The bench first pulses requests during power-up and during the init refreshes. A design that leaks them would push an extra read or write into the init stream, and the scoreboard reports that command as unexpected. The bench then places a read request on the exact edge at which a refresh falls due. A design that lets the user win would issue a read before the precharge, or would shift the refresh spacing. Other checks cover the following:
- A simultaneous read and write, where the wrong choice of operation shows up as a code mismatch.
- The NOP gap after every acknowledge.
- The exact length of the data window, which catches an off-by-one in the beat counter.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP         = 3'b000,
        CMD_READ        = 3'b001,
        CMD_WRITE       = 3'b010,
        CMD_REFRESH     = 3'b011,
        CMD_PRECHARGE   = 3'b100,
        CMD_LOAD_MODE   = 3'b101,
        CMD_LOAD_CTRL   = 3'b110,
        CMD_LOAD_REFCNT = 3'b111
    } cmd_e;

    typedef enum logic [3:0] {
        ST_WAIT_PWR,
        ST_INIT_PRE,
        ST_INIT_REF,
        ST_INIT_MODE,
        ST_INIT_CTRL,
        ST_INIT_RCNT,
        ST_IDLE,
        ST_RUN_PRE,
        ST_RUN_REF,
        ST_XFER_CMD,
        ST_XFER_DATA
    } seq_state_e;

    // bus bit that selects all banks on a precharge
    localparam int PRE_ALL_BIT = 10;

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
    parameter int CYCLES = 26600
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(CYCLES) + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(CYCLES - 1)) done <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end

    // R1: once the delay has elapsed it stays elapsed
    a_r1_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int PERIOD = 1037
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic take,
    output logic due
);
    localparam int CW = $clog2(PERIOD) + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= CW'(PERIOD - 1);
            due <= 1'b0;
        end else begin
            if (take) due <= 1'b0;
            if (cnt == '0) begin
                cnt <= CW'(PERIOD - 1);
                due <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R9: a pending refresh is never lost before it is taken
    a_r9_due_held: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !take && run) |=> due);

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_seq_pkg::*;
#(
    parameter int              ADDR_W         = 22,
    parameter int              INIT_REFRESHES = 8,
    parameter int              DATA_BEATS     = 4,
    parameter int              REF_PERIOD     = 1037,
    parameter logic [ADDR_W-1:0] MODE_WORD    = '0,
    parameter logic [ADDR_W-1:0] CTRL_WORD    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_done,
    input  logic              ref_due,
    output logic              ref_take,
    output logic              init_done,
    input  logic              usr_rd,
    input  logic              usr_wr,
    input  logic [ADDR_W-1:0] usr_addr,
    output logic              usr_busy,
    output logic              usr_data_en,
    output logic [2:0]        eng_cmd,
    output logic [ADDR_W-1:0] eng_bus,
    input  logic              eng_ack
);
    localparam int RW = $clog2(INIT_REFRESHES + 1);
    localparam int BW = $clog2(DATA_BEATS + 1);
    localparam logic [ADDR_W-1:0] PRE_ALL = ADDR_W'(1) << PRE_ALL_BIT;
    localparam logic [ADDR_W-1:0] RCNT_WORD = ADDR_W'(REF_PERIOD);

    seq_state_e        state, state_nx;
    cmd_e              cmd_q, op_q;
    logic [ADDR_W-1:0] bus_q, addr_q;
    logic [RW-1:0]     ref_left;
    logic [BW-1:0]     beat;
    logic              ack_hit, req_any;

    assign ack_hit  = eng_ack && (cmd_q != CMD_NOP);
    assign req_any  = usr_rd || usr_wr;
    assign ref_take = (state == ST_IDLE) && ref_due;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_PWR:  if (pwr_done) state_nx = ST_INIT_PRE;
            ST_INIT_PRE:  if (ack_hit) state_nx = ST_INIT_REF;
            ST_INIT_REF:  if (ack_hit && ref_left == RW'(1)) state_nx = ST_INIT_MODE;
            ST_INIT_MODE: if (ack_hit) state_nx = ST_INIT_CTRL;
            ST_INIT_CTRL: if (ack_hit) state_nx = ST_INIT_RCNT;
            ST_INIT_RCNT: if (ack_hit) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (ref_due)      state_nx = ST_RUN_PRE;
                else if (req_any) state_nx = ST_XFER_CMD;
            end
            ST_RUN_PRE:   if (ack_hit) state_nx = ST_RUN_REF;
            ST_RUN_REF:   if (ack_hit) state_nx = ST_IDLE;
            ST_XFER_CMD:  if (ack_hit) state_nx = ST_XFER_DATA;
            ST_XFER_DATA: if (beat == BW'(DATA_BEATS - 1)) state_nx = ST_IDLE;
            default:      state_nx = ST_WAIT_PWR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_PWR;
        else        state <= state_nx;
    end

    // counters and request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_left  <= RW'(INIT_REFRESHES);
            beat      <= '0;
            addr_q    <= '0;
            op_q      <= CMD_READ;
            init_done <= 1'b0;
        end else begin
            if (state == ST_INIT_REF && ack_hit) ref_left <= ref_left - 1'b1;
            beat <= (state == ST_XFER_DATA) ? beat + 1'b1 : '0;
            if (state == ST_IDLE) begin
                init_done <= 1'b1;
                if (!ref_due && req_any) begin
                    addr_q <= usr_addr;
                    op_q   <= usr_rd ? CMD_READ : CMD_WRITE;
                end
            end
        end
    end

    // command outputs
    always_ff @(posedge clk) begin
        if (!rst_n || ack_hit) begin
            cmd_q <= CMD_NOP;
            bus_q <= '0;
        end else begin
            unique case (state)
                ST_INIT_PRE, ST_RUN_PRE: begin cmd_q <= CMD_PRECHARGE;   bus_q <= PRE_ALL;   end
                ST_INIT_REF, ST_RUN_REF: begin cmd_q <= CMD_REFRESH;     bus_q <= '0;        end
                ST_INIT_MODE:            begin cmd_q <= CMD_LOAD_MODE;   bus_q <= MODE_WORD; end
                ST_INIT_CTRL:            begin cmd_q <= CMD_LOAD_CTRL;   bus_q <= CTRL_WORD; end
                ST_INIT_RCNT:            begin cmd_q <= CMD_LOAD_REFCNT; bus_q <= RCNT_WORD; end
                ST_XFER_CMD:             begin cmd_q <= op_q;            bus_q <= addr_q;    end
                default:                 begin cmd_q <= CMD_NOP;         bus_q <= '0;        end
            endcase
        end
    end

    assign eng_cmd     = cmd_q;
    assign eng_bus     = bus_q;
    assign usr_busy    = (state != ST_IDLE);
    assign usr_data_en = (state == ST_XFER_DATA);

    // R1: nothing leaves before the power-up delay has run out
    a_r1_quiet_before_power: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_done |-> eng_cmd == CMD_NOP);

    // R3: an acknowledged command is followed by NOP
    a_r3_nop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_ack && eng_cmd != CMD_NOP) |=> eng_cmd == CMD_NOP);

    // R4: command and bus hold while unacknowledged
    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cmd != CMD_NOP && !eng_ack) |=> ($stable(eng_cmd) && $stable(eng_bus)));

    // R7: a transfer command only follows an idle cycle
    a_r7_accept_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_cmd == CMD_READ || eng_cmd == CMD_WRITE) && $past(eng_cmd) == CMD_NOP)
        |-> !$past(usr_busy, 2));

    // R8: the data window opens right after a transfer acknowledge
    a_r8_window_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usr_data_en) |-> ($past(eng_ack) &&
            ($past(eng_cmd) == CMD_READ || $past(eng_cmd) == CMD_WRITE)));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int              ADDR_W         = 22,
    parameter int              PWRUP_CYCLES   = 26600,
    parameter int              INIT_REFRESHES = 8,
    parameter int              REF_PERIOD     = 1037,
    parameter int              DATA_BEATS     = 4,
    parameter logic [ADDR_W-1:0] MODE_WORD    = ADDR_W'(32'h0000_0027),
    parameter logic [ADDR_W-1:0] CTRL_WORD    = ADDR_W'(32'h0000_0123)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_rd,
    input  logic              usr_wr,
    input  logic [ADDR_W-1:0] usr_addr,
    output logic              usr_busy,
    output logic              usr_data_en,
    output logic [2:0]        eng_cmd,
    output logic [ADDR_W-1:0] eng_bus,
    input  logic              eng_ack
);
    logic pwr_done, ref_due, ref_take, init_done;

    sdram_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) pwr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    sdram_refresh_timer #(.PERIOD(REF_PERIOD)) rft_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (init_done),
        .take  (ref_take),
        .due   (ref_due)
    );

    sdram_seq_fsm #(
        .ADDR_W         (ADDR_W),
        .INIT_REFRESHES (INIT_REFRESHES),
        .DATA_BEATS     (DATA_BEATS),
        .REF_PERIOD     (REF_PERIOD),
        .MODE_WORD      (MODE_WORD),
        .CTRL_WORD      (CTRL_WORD)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_done    (pwr_done),
        .ref_due     (ref_due),
        .ref_take    (ref_take),
        .init_done   (init_done),
        .usr_rd      (usr_rd),
        .usr_wr      (usr_wr),
        .usr_addr    (usr_addr),
        .usr_busy    (usr_busy),
        .usr_data_en (usr_data_en),
        .eng_cmd     (eng_cmd),
        .eng_bus     (eng_bus),
        .eng_ack     (eng_ack)
    );

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 8;
    localparam int P_AW   = 22;
    localparam int P_PWR  = 100;
    localparam int P_NREF = 8;
    localparam int P_REF  = 200;
    localparam int P_DB   = 4;
    localparam int ACK_LAT = 2;
    localparam logic [P_AW-1:0] P_MODE = 22'h000032;
    localparam logic [P_AW-1:0] P_CTRL = 22'h000155;
    localparam logic [P_AW-1:0] PRE_BUS = 22'h000400;
    localparam int INIT_ITEMS = P_NREF + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic usr_rd = 1'b0, usr_wr = 1'b0;
    logic [P_AW-1:0] usr_addr = '0;
    logic usr_busy, usr_data_en;
    logic [2:0] eng_cmd;
    logic [P_AW-1:0] eng_bus;
    logic eng_ack = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_seq #(
        .ADDR_W(P_AW), .PWRUP_CYCLES(P_PWR), .INIT_REFRESHES(P_NREF),
        .REF_PERIOD(P_REF), .DATA_BEATS(P_DB), .MODE_WORD(P_MODE), .CTRL_WORD(P_CTRL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .usr_rd(usr_rd), .usr_wr(usr_wr),
        .usr_addr(usr_addr), .usr_busy(usr_busy), .usr_data_en(usr_data_en),
        .eng_cmd(eng_cmd), .eng_bus(eng_bus), .eng_ack(eng_ack)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard queues
    logic [2:0]      q_code[$];
    logic [P_AW-1:0] q_bus[$];
    string           q_tag[$];

    task automatic push(input logic [2:0] c, input logic [P_AW-1:0] b, input string t);
        q_code.push_back(c); q_bus.push_back(b); q_tag.push_back(t);
    endtask

    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc++;

    // monitor and engine model
    logic [2:0]      prev_cmd = '0;
    logic [P_AW-1:0] prev_bus = '0;
    int  dwin = 0, acnt = 0, init_pops = 0, auto_cnt = 0, last_pre = 0;
    bit  pend = 0, ack_q = 0, exp_ref = 0, first_seen = 0, quiet = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dwin > 0) begin
                chk(usr_data_en === 1'b1, "R8 window", 32'(usr_data_en), 1);
                dwin--;
            end else begin
                chk(usr_data_en === 1'b0, "R8 closed", 32'(usr_data_en), 0);
            end
            if (ack_q) begin
                chk(eng_cmd == 3'b000, "R3 nop after ack", 32'(eng_cmd), 0);
                eng_ack = 1'b0;
                ack_q = 0;
            end
            if (eng_cmd != 3'b000) begin
                if (prev_cmd != 3'b000) begin
                    chk(eng_cmd == prev_cmd && eng_bus == prev_bus, "R4 hold",
                        32'(eng_cmd), 32'(prev_cmd));
                end else begin
                    pend = 1; acnt = ACK_LAT;
                    if (!first_seen) begin
                        first_seen = 1;
                        chk(cyc >= P_PWR && cyc <= P_PWR + 2, "R1 powerup delay", cyc, P_PWR);
                    end
                    if (init_pops == INIT_ITEMS && eng_cmd == 3'b100 && !exp_ref) begin
                        chk(eng_bus == PRE_BUS, "R9 precharge bus", 32'(eng_bus), 32'(PRE_BUS));
                        if (quiet && auto_cnt > 0)
                            chk(cyc - last_pre == P_REF, "R9 spacing", cyc - last_pre, P_REF);
                        last_pre = cyc;
                        auto_cnt++;
                        exp_ref = 1;
                    end else if (exp_ref) begin
                        chk(eng_cmd == 3'b011 && eng_bus == '0, "R9 refresh", 32'(eng_cmd), 3);
                        exp_ref = 0;
                    end else if (q_code.size() == 0) begin
                        chk(0, "R7 unexpected command", 32'(eng_cmd), 0);
                    end else begin
                        automatic logic [2:0] ec = q_code.pop_front();
                        automatic logic [P_AW-1:0] eb = q_bus.pop_front();
                        automatic string et = q_tag.pop_front();
                        chk(eng_cmd == ec, {et, " code"}, 32'(eng_cmd), 32'(ec));
                        chk(eng_bus == eb, {et, " bus"}, 32'(eng_bus), 32'(eb));
                        if (init_pops < INIT_ITEMS) init_pops++;
                    end
                end
            end
            prev_cmd = eng_cmd;
            prev_bus = eng_bus;
            if (pend) begin
                if (acnt == 0) begin
                    eng_ack = 1'b1; ack_q = 1; pend = 0;
                    if (eng_cmd == 3'b001 || eng_cmd == 3'b010) dwin = P_DB;
                end else begin
                    acnt--;
                end
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (usr_busy) @(negedge clk);
    endtask

    task automatic wait_refresh();
        automatic int n = auto_cnt;
        while (auto_cnt == n) @(negedge clk);
        wait_idle();
    endtask

    task automatic access(input bit rd, input bit wr, input logic [P_AW-1:0] a,
                          input logic [2:0] exp, input string tag);
        while (usr_busy) @(negedge clk);
        push(exp, a, tag);
        usr_rd = rd; usr_wr = wr; usr_addr = a;
        @(negedge clk);
        usr_rd = 0; usr_wr = 0;
        chk(usr_busy == 1'b1, "R7 busy after accept", 32'(usr_busy), 1);
        usr_wr = 1; usr_addr = ~a;
        @(negedge clk);
        usr_wr = 0;
        chk(usr_busy == 1'b1, "R7 busy during transfer", 32'(usr_busy), 1);
        wait_idle();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(eng_cmd == 3'b000, "R1 reset cmd", 32'(eng_cmd), 0);
        chk(usr_busy == 1'b1, "R1 reset busy", 32'(usr_busy), 1);
        chk(usr_data_en == 1'b0, "R1 reset data_en", 32'(usr_data_en), 0);
        push(3'b100, PRE_BUS, "R2 init precharge");
        for (int i = 0; i < P_NREF; i++) push(3'b011, '0, "R2 init refresh");
        push(3'b101, P_MODE, "R2 load mode");
        push(3'b110, P_CTRL, "R2 load ctrl");
        push(3'b111, P_AW'(P_REF), "R2 load refcnt");
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        usr_wr = 1; usr_addr = 22'h0ABCDE;
        @(negedge clk);
        usr_wr = 0;
        chk(usr_busy == 1'b1, "R7 busy in powerup", 32'(usr_busy), 1);
        while (cyc < P_PWR + 10) @(negedge clk);
        usr_rd = 1; usr_addr = 22'h012345;
        @(negedge clk);
        usr_rd = 0;
        chk(usr_busy == 1'b1, "R7 busy in init", 32'(usr_busy), 1);
        wait_idle();
        chk(q_code.size() == 0, "R2 init complete", q_code.size(), 0);
        chk(usr_busy == 1'b0, "R7 idle after init", 32'(usr_busy), 0);

        wait_refresh();
        access(1, 0, 22'h1F0A55, 3'b001, "R5 read");
        access(0, 1, 22'h02C3B7, 3'b010, "R6 write");
        access(1, 1, 22'h3FFFFF, 3'b001, "R11 read wins");
        access(0, 1, 22'h000000, 3'b010, "R6 write zero");

        quiet = 1;
        wait_refresh();
        while (cyc < last_pre - 2 + P_REF) @(negedge clk);
        usr_rd = 1; usr_addr = 22'h155AA0;
        @(negedge clk);
        usr_rd = 0;
        chk(usr_busy == 1'b1, "R10 refresh taken", 32'(usr_busy), 1);
        wait_idle();
        chk(q_code.size() == 0, "R10 request dropped", q_code.size(), 0);
        wait_refresh();
        chk(auto_cnt >= 4, "R9 refresh count", auto_cnt, 4);
        chk(q_code.size() == 0, "R7 queue drained", q_code.size(), 0);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
    end

endmodule